// File: doc/BRIEF.md
# Stack and Interrupt Vector Sequencer

This block runs the memory traffic that an 8-bit processor core needs for stack operations and for the entries into its exception handlers. The surrounding core decodes opcodes and owns the ALU. It hands this block a command, the current program counter and the current status byte. The block then issues one single-byte memory access per clock on a 16-bit address bus and keeps the 8-bit stack pointer. When the sequence completes it raises a one-cycle `done` and presents the new program counter, the new status byte and any pulled byte. The core is expected to adopt these values when it sees `done`.

The stack sits in page 1 of memory, at address `0x0100 + sp`, and grows downward from `0x01FF`. A reset request, a rising edge on the non-maskable interrupt line, or a level on the maskable interrupt line starts an entry sequence on its own whenever the block is idle. A vector is fetched low byte first from a fixed pair of addresses for each source: `0xFFFA` for the non-maskable interrupt, `0xFFFC` for reset, and `0xFFFE` for the maskable interrupt and for software break.

Commands arrive on a valid/ready handshake. `cmd_valid` must stay high, with `cmd_code`, `cmd_operand` and `push_data` held steady, until a clock edge at which `cmd_ready` is high. `cmd_ready` is high only when the block is idle and no interrupt or reset is pending, so pending events always win over a waiting command. The memory side and every other pin are plain signals with no handshake. Read data must be returned combinationally in the same cycle as the address.

Top module: `stack_vector_seq`

## Requirements
- R1: After reset, `sp` is `0xFF`. Every stack write goes to address `{0x01, sp}` and every stack read goes to `{0x01, sp+1}`, so all stack traffic stays in page 1 and `sp` wraps within 8 bits.
- R2: Command code 0 (push) writes `push_data` at the current `sp` and then decrements `sp`. Command code 1 (pull) increments `sp`, reads that location and presents the byte on `pull_data`. A pull with `sp = 0xFF` reads `0x0100` and leaves `sp = 0x00`.
- R3: Command code 2 (call) pushes `pc_in+2`, high byte first and then low byte. It sets `pc_out` to `cmd_operand`.
- R4: Command code 3 (return) pulls the low byte and then the high byte. It sets `pc_out` to the pulled address plus one, wrapping from `0xFFFF` to `0x0000`.
- R5: Command code 4 (break) pushes `pc_in+2` (high byte, then low byte), then pushes `p_in` with bit 4 set. It then reads `0xFFFE` and `0xFFFF` into `pc_out` and sets `p_out = p_in | 0x04`. The sequence spans 7 cycles, counting the accept cycle and the `done` cycle.
- R6: Command code 5 (interrupt return) pulls the status byte, then the low byte, then the high byte of the PC. It sets `p_out` to the pulled status with bit 4 cleared.
- R7: A pulse on `rst_req` starts a sequence that performs no memory writes and leaves `sp` unchanged. It reads `0xFFFC`/`0xFFFD` into `pc_out`, sets `p_out = p_in | 0x04` and reports `done_op = 6`.
- R8: A rising edge on `nmi_req` starts an entry that pushes `pc_in` (high byte, then low byte) and then `p_in` with bit 4 cleared. It loads `pc_out` from `0xFFFA`/`0xFFFB`, sets bit 2 of `p_out` and reports `done_op = 7`. Holding `nmi_req` high causes only one entry.
- R9: A high level on `irq_req` starts the same entry as R8, but with vector `0xFFFE`/`0xFFFF` and `done_op = 8`. It is ignored while `p_in` bit 2 is set.
- R10: Priority is reset, then non-maskable interrupt, then maskable interrupt, then command. While any of these events is pending, `cmd_ready` is low and a held command waits.
- R11: `done` is a single-cycle pulse. `done_op` gives the command code (0 to 5) or entry code (6 to 8) of the finished sequence. `cmd_ready` is never high while a sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| rst_req | input | 1 | Request to run the reset-vector sequence |
| nmi_req | input | 1 | Non-maskable interrupt line, edge sensitive |
| irq_req | input | 1 | Maskable interrupt line, level sensitive |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted at this edge when valid is also high |
| cmd_code | input | 3 | Command code 0 to 5 (6 and 7 reserved) |
| cmd_operand | input | 16 | Call target address |
| push_data | input | 8 | Byte stored by a push |
| pc_in | input | 16 | Current program counter |
| p_in | input | 8 | Current status byte (bit 4 break, bit 2 interrupt disable) |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write strobe; low means read |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, same cycle |
| sp | output | 8 | Stack pointer |
| pc_out | output | 16 | New program counter, valid while done |
| p_out | output | 8 | New status byte, valid while done |
| pull_data | output | 8 | Byte returned by the last pull |
| done | output | 1 | Sequence finished |
| done_op | output | 4 | Code of the sequence reported by done |

## Verification
The assertions assume that memory answers reads in the same cycle and that `p_in` stays steady while a sequence runs. They also assume that `cmd_code` never carries the reserved values 6 or 7. The stimulus changes `pc_in`, `p_in` and the command fields only at the negative edge before a command is offered, and it issues only codes 0 to 5. Interrupt lines are raised at least one cycle before a competing command is offered, so the pending event is already registered when priority is tested.

// File: rtl/svs_pkg.sv
package svs_pkg;

  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 16;
  localparam int unsigned IDX_W   = 3;
  localparam logic [7:0]  STK_PG  = 8'h01;
  localparam int unsigned BIT_B   = 4;
  localparam int unsigned BIT_I   = 2;
  localparam logic [15:0] VEC_NMI = 16'hFFFA;
  localparam logic [15:0] VEC_RST = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ = 16'hFFFE;

  typedef enum logic [3:0] {
    OP_PUSH = 4'd0, OP_PULL = 4'd1, OP_JSR = 4'd2, OP_RTS = 4'd3,
    OP_BRK  = 4'd4, OP_RTI  = 4'd5, OP_RESET = 4'd6, OP_NMI = 4'd7,
    OP_IRQ  = 4'd8
  } op_e;

  typedef enum logic [3:0] {
    U_WR_PCH, U_WR_PCL, U_WR_P, U_WR_DAT,
    U_RD_P, U_RD_PCL, U_RD_PCH, U_RD_DAT,
    U_RD_VL, U_RD_VH
  } uop_e;

  typedef struct packed {
    uop_e kind;
    logic last;
  } ustep_t;

  function automatic ustep_t step_of(op_e op, logic [IDX_W-1:0] idx);
    ustep_t s;
    s = '{kind: U_RD_VH, last: 1'b1};
    case (op)
      OP_PUSH: s = '{kind: U_WR_DAT, last: 1'b1};
      OP_PULL: s = '{kind: U_RD_DAT, last: 1'b1};
      OP_JSR: begin
        if (idx == 0) s = '{kind: U_WR_PCH, last: 1'b0};
        else          s = '{kind: U_WR_PCL, last: 1'b1};
      end
      OP_RTS: begin
        if (idx == 0) s = '{kind: U_RD_PCL, last: 1'b0};
        else          s = '{kind: U_RD_PCH, last: 1'b1};
      end
      OP_RTI: begin
        case (idx)
          3'd0:    s = '{kind: U_RD_P,   last: 1'b0};
          3'd1:    s = '{kind: U_RD_PCL, last: 1'b0};
          default: s = '{kind: U_RD_PCH, last: 1'b1};
        endcase
      end
      OP_RESET: begin
        if (idx == 0) s = '{kind: U_RD_VL, last: 1'b0};
        else          s = '{kind: U_RD_VH, last: 1'b1};
      end
      default: begin
        case (idx)
          3'd0:    s = '{kind: U_WR_PCH, last: 1'b0};
          3'd1:    s = '{kind: U_WR_PCL, last: 1'b0};
          3'd2:    s = '{kind: U_WR_P,   last: 1'b0};
          3'd3:    s = '{kind: U_RD_VL,  last: 1'b0};
          default: s = '{kind: U_RD_VH,  last: 1'b1};
        endcase
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/svs_intr_arb.sv
module svs_intr_arb
  import svs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  input  logic nmi_req,
  input  logic irq_req,
  input  logic irq_mask,
  input  logic grant,
  output logic pend_any,
  output op_e  pend_op
);

  logic rst_pend, nmi_q, nmi_pend, irq_q, irq_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend <= 1'b0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      nmi_q <= nmi_req;
      irq_q <= irq_req;
      if (rst_req)                            rst_pend <= 1'b1;
      else if (grant && pend_op == OP_RESET)  rst_pend <= 1'b0;
      if (nmi_req && !nmi_q)                  nmi_pend <= 1'b1;
      else if (grant && pend_op == OP_NMI)    nmi_pend <= 1'b0;
    end
  end

  assign irq_live = irq_q && !irq_mask;
  assign pend_any = rst_pend || nmi_pend || irq_live;

  always_comb begin
    if (rst_pend)      pend_op = OP_RESET;
    else if (nmi_pend) pend_op = OP_NMI;
    else               pend_op = OP_IRQ;
  end

  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && pend_op == OP_NMI && nmi_req && nmi_q) |=> !nmi_pend); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && pend_op == OP_IRQ) |-> !irq_mask); // R9

endmodule

// File: rtl/svs_addr_gen.sv
module svs_addr_gen
  import svs_pkg::*;
(
  input  logic          active,
  input  uop_e          kind,
  input  op_e           op,
  input  logic [DW-1:0] sp,
  input  logic [AW-1:0] pc_hold,
  input  logic [DW-1:0] p_hold,
  input  logic [DW-1:0] dat_hold,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] sp_nxt
);

  logic [AW-1:0] vec;
  logic [DW-1:0] sp_up;

  assign sp_up = sp + 8'd1;

  always_comb begin
    case (op)
      OP_NMI:   vec = VEC_NMI;
      OP_RESET: vec = VEC_RST;
      default:  vec = VEC_IRQ;
    endcase
  end

  always_comb begin
    addr   = '0;
    we     = 1'b0;
    wdata  = '0;
    sp_nxt = sp;
    if (active) begin
      case (kind)
        U_WR_PCH, U_WR_PCL, U_WR_P, U_WR_DAT: begin
          addr   = {STK_PG, sp};
          we     = 1'b1;
          sp_nxt = sp - 8'd1;
          case (kind)
            U_WR_PCH: wdata = pc_hold[15:8];
            U_WR_PCL: wdata = pc_hold[7:0];
            U_WR_P:   wdata = p_hold;
            default:  wdata = dat_hold;
          endcase
        end
        U_RD_VL: addr = vec;
        U_RD_VH: addr = vec | 16'h0001;
        default: begin
          addr   = {STK_PG, sp_up};
          sp_nxt = sp_up;
        end
      endcase
    end
  end

endmodule

// File: rtl/svs_seq.sv
module svs_seq
  import svs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_code,
  input  logic [AW-1:0] cmd_operand,
  input  logic [DW-1:0] push_data,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] p_in,
  input  logic          pend_any,
  input  op_e           pend_op,
  output logic          grant,
  output logic          active,
  output uop_e          kind,
  output op_e           op,
  output logic [AW-1:0] pc_hold,
  output logic [DW-1:0] p_hold,
  output logic [DW-1:0] dat_hold,
  output logic [DW-1:0] sp,
  input  logic [DW-1:0] sp_nxt,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] p_out,
  output logic [DW-1:0] pull_data,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

  st_e              st;
  op_e              op_q;
  logic [IDX_W-1:0] idx;
  ustep_t           cur;
  logic [AW-1:0]    opnd_q, pc_keep, pc_new;
  logic [DW-1:0]    lo_q, hi_q, p_rd, p_base, p_keep, p_new;
  logic             accept;

  assign cur       = step_of(op_q, idx);
  assign kind      = cur.kind;
  assign op        = op_q;
  assign active    = (st == S_RUN);
  assign done      = (st == S_FIN);
  assign grant     = (st == S_IDLE) && pend_any;
  assign cmd_ready = (st == S_IDLE) && !pend_any;
  assign accept    = cmd_ready && cmd_valid;

  always_comb begin
    pc_new = pc_keep;
    p_new  = p_keep;
    case (op_q)
      OP_JSR: pc_new = opnd_q;
      OP_RTS: pc_new = {hi_q, lo_q} + 16'd1;
      OP_RTI: begin
        pc_new = {hi_q, lo_q};
        p_new  = p_rd & ~(8'd1 << BIT_B);
      end
      OP_BRK, OP_NMI, OP_IRQ, OP_RESET: begin
        pc_new = {hi_q, lo_q};
        p_new  = p_base | (8'd1 << BIT_I);
      end
      default: ;
    endcase
  end

  assign pc_out = done ? pc_new : pc_keep;
  assign p_out  = done ? p_new  : p_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= OP_PUSH;
      idx       <= '0;
      sp        <= 8'hFF;
      pc_hold   <= '0;
      p_hold    <= '0;
      p_base    <= '0;
      dat_hold  <= '0;
      opnd_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      p_rd      <= '0;
      pull_data <= '0;
      pc_keep   <= '0;
      p_keep    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          idx <= '0;
          if (grant) begin
            op_q    <= pend_op;
            pc_hold <= pc_in;
            p_hold  <= p_in & ~(8'd1 << BIT_B);
            p_base  <= p_in;
            st      <= S_RUN;
          end else if (accept) begin
            op_q     <= op_e'({1'b0, cmd_code});
            pc_hold  <= pc_in + 16'd2;
            p_hold   <= p_in | (8'd1 << BIT_B);
            p_base   <= p_in;
            dat_hold <= push_data;
            opnd_q   <= cmd_operand;
            st       <= S_RUN;
          end
        end
        S_RUN: begin
          sp <= sp_nxt;
          case (cur.kind)
            U_RD_P:            p_rd      <= mem_rdata;
            U_RD_PCL, U_RD_VL: lo_q      <= mem_rdata;
            U_RD_PCH, U_RD_VH: hi_q      <= mem_rdata;
            U_RD_DAT:          pull_data <= mem_rdata;
            default: ;
          endcase
          if (cur.last) st <= S_FIN;
          else          idx <= idx + 3'd1;
        end
        default: begin
          pc_keep <= pc_new;
          p_keep  <= p_new;
          st      <= S_IDLE;
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!done && !active)); // R11

  AST_ENTRY_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_BRK || op_q == OP_NMI || op_q == OP_IRQ || op_q == OP_RESET))
      |-> p_out[BIT_I]); // R5

  AST_RTI_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_RTI) |-> !p_out[BIT_B]); // R6

endmodule

// File: rtl/stack_vector_seq.sv
module stack_vector_seq
  import svs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_req,
  input  logic        nmi_req,
  input  logic        irq_req,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_code,
  input  logic [15:0] cmd_operand,
  input  logic [7:0]  push_data,
  input  logic [15:0] pc_in,
  input  logic [7:0]  p_in,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  sp,
  output logic [15:0] pc_out,
  output logic [7:0]  p_out,
  output logic [7:0]  pull_data,
  output logic        done,
  output logic [3:0]  done_op
);

  logic          pend_any, grant, active;
  op_e           pend_op, op;
  uop_e          kind;
  logic [AW-1:0] pc_hold;
  logic [DW-1:0] p_hold, dat_hold, sp_nxt;

  svs_intr_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req),
    .nmi_req  (nmi_req),
    .irq_req  (irq_req),
    .irq_mask (p_in[BIT_I]),
    .grant    (grant),
    .pend_any (pend_any),
    .pend_op  (pend_op)
  );

  svs_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_code    (cmd_code),
    .cmd_operand (cmd_operand),
    .push_data   (push_data),
    .pc_in       (pc_in),
    .p_in        (p_in),
    .pend_any    (pend_any),
    .pend_op     (pend_op),
    .grant       (grant),
    .active      (active),
    .kind        (kind),
    .op          (op),
    .pc_hold     (pc_hold),
    .p_hold      (p_hold),
    .dat_hold    (dat_hold),
    .sp          (sp),
    .sp_nxt      (sp_nxt),
    .mem_rdata   (mem_rdata),
    .pc_out      (pc_out),
    .p_out       (p_out),
    .pull_data   (pull_data),
    .done        (done)
  );

  svs_addr_gen u_addr (
    .active   (active),
    .kind     (kind),
    .op       (op),
    .sp       (sp),
    .pc_hold  (pc_hold),
    .p_hold   (p_hold),
    .dat_hold (dat_hold),
    .addr     (mem_addr),
    .we       (mem_we),
    .wdata    (mem_wdata),
    .sp_nxt   (sp_nxt)
  );

  assign done_op = op;

  AST_WR_IN_PAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] == STK_PG)); // R1

  AST_WR_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[7:0] == sp)); // R2

  AST_WR_THEN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - 8'd1)); // R2

  AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && done_op == 4'd6) |-> !mem_we); // R7

endmodule

// File: tb/test_stack_vector_seq.sv
module test_stack_vector_seq;

  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 20000;
  localparam int NROWS = 8;

  // {code3, operand16, pc_in16, p_in8, data8, exp_sp8, exp_pc16, exp_p8, exp_pull8, chk_pc/p/pull}
  localparam logic [93:0] TBL [NROWS] = '{
    {3'd0, 16'h0000, 16'h0000, 8'h00, 8'hA5, 8'hFE, 16'h0000, 8'h00, 8'h00, 3'b000},
    {3'd0, 16'h0000, 16'h0000, 8'h00, 8'h3C, 8'hFD, 16'h0000, 8'h00, 8'h00, 3'b000},
    {3'd1, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'hFE, 16'h0000, 8'h00, 8'h3C, 3'b001},
    {3'd2, 16'h8000, 16'h1234, 8'h00, 8'h00, 8'hFC, 16'h8000, 8'h00, 8'h00, 3'b100},
    {3'd3, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'hFE, 16'h1237, 8'h00, 8'h00, 3'b100},
    {3'd1, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'hFF, 16'h0000, 8'h00, 8'hA5, 3'b001},
    {3'd4, 16'h0000, 16'h4000, 8'h81, 8'h00, 8'hFC, 16'hC0DE, 8'h85, 8'h00, 3'b110},
    {3'd5, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'hFF, 16'h4002, 8'h81, 8'h00, 3'b110}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req = 1'b0, nmi_req = 1'b0, irq_req = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_code = '0;
  logic [15:0] cmd_operand = '0;
  logic [7:0]  push_data = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  p_in = '0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic [7:0]  sp;
  logic [15:0] pc_out;
  logic [7:0]  p_out, pull_data;
  logic        done;
  logic [3:0]  done_op;

  logic [7:0]  stk [256];
  int          wr_cnt;
  int          n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  stack_vector_seq i_stack_vector_seq (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req), .irq_req(irq_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_operand(cmd_operand), .push_data(push_data), .pc_in(pc_in), .p_in(p_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sp(sp), .pc_out(pc_out), .p_out(p_out), .pull_data(pull_data),
    .done(done), .done_op(done_op)
  );

  always_comb begin
    mem_rdata = 8'h00;
    if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
    else begin
      case (mem_addr)
        16'hFFFA: mem_rdata = 8'hBC;
        16'hFFFB: mem_rdata = 8'h9A;
        16'hFFFC: mem_rdata = 8'h00;
        16'hFFFD: mem_rdata = 8'hE0;
        16'hFFFE: mem_rdata = 8'hDE;
        16'hFFFF: mem_rdata = 8'hC0;
        default:  mem_rdata = 8'h00;
      endcase
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) stk[i] <= 8'h00;
      stk[0] <= 8'h5A;
      wr_cnt <= 0;
    end else if (mem_we) begin
      stk[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [2:0] code, input logic [15:0] opnd,
                         input logic [15:0] pci, input logic [7:0] pi,
                         input logic [7:0] dat, output int cyc);
    @(negedge clk);
    cmd_code = code; cmd_operand = opnd; pc_in = pci; p_in = pi; push_data = dat;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    cyc = 1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 2;
    while (!done) begin @(negedge clk); cyc++; end
  endtask

  task automatic quiet(input int n, input string req);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(req, {31'd0, seen}, 32'd0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [93:0] r;
    logic [2:0]  code;
    int          cyc;
    int          wsave;
    string       rq;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 sp", {24'd0, sp}, 32'hFF);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 ready", {31'd0, cmd_ready}, 32'd1);
    chk("R1 we", {31'd0, mem_we}, 32'd0);

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      r = TBL[i];
      code = r[93:91];
      run_cmd(code, r[90:75], r[74:59], r[58:51], r[50:43], cyc);
      case (code)
        3'd0, 3'd1: rq = "R2";
        3'd2:       rq = "R3";
        3'd3:       rq = "R4";
        3'd4:       rq = "R5";
        default:    rq = "R6";
      endcase
      chk({rq, " done_op"}, {28'd0, done_op}, {29'd0, code});
      chk({"R1 sp ", rq}, {24'd0, sp}, {24'd0, r[42:35]});
      if (r[2]) chk({rq, " pc"}, {16'd0, pc_out}, {16'd0, r[34:19]});
      if (r[1]) chk({rq, " p"}, {24'd0, p_out}, {24'd0, r[18:11]});
      if (r[0]) chk({rq, " pull"}, {24'd0, pull_data}, {24'd0, r[10:3]});
      if (code == 3'd2) begin
        chk("R3 hi byte", {24'd0, stk[8'hFE]}, 32'h12);
        chk("R3 lo byte", {24'd0, stk[8'hFD]}, 32'h36);
      end
      if (code == 3'd4) begin
        chk("R5 cycles", cyc, 7);
        chk("R5 hi byte", {24'd0, stk[8'hFF]}, 32'h40);
        chk("R5 lo byte", {24'd0, stk[8'hFE]}, 32'h02);
        chk("R5 pushed p", {24'd0, stk[8'hFD]}, 32'h91);
      end
    end

    // R2: pull wraps from 0xFF to 0x00, push wraps back
    run_cmd(3'd1, 16'h0, 16'h0, 8'h00, 8'h00, cyc);
    chk("R2 wrap pull", {24'd0, pull_data}, 32'h5A);
    chk("R2 wrap sp", {24'd0, sp}, 32'h00);
    run_cmd(3'd0, 16'h0, 16'h0, 8'h00, 8'h77, cyc);
    chk("R2 wrap push sp", {24'd0, sp}, 32'hFF);
    chk("R1 wrote 0100", {24'd0, stk[8'h00]}, 32'h77);

    // R4: return address wraps
    run_cmd(3'd0, 16'h0, 16'h0, 8'h00, 8'hFF, cyc);
    run_cmd(3'd0, 16'h0, 16'h0, 8'h00, 8'hFF, cyc);
    run_cmd(3'd3, 16'h0, 16'h0, 8'h00, 8'h00, cyc);
    chk("R4 wrap pc", {16'd0, pc_out}, 32'h0000);
    chk("R4 sp", {24'd0, sp}, 32'hFF);

    // R7: reset sequence
    @(negedge clk);
    p_in = 8'h01;
    wsave = wr_cnt;
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    wait_done();
    chk("R7 done_op", {28'd0, done_op}, 32'd6);
    chk("R7 pc", {16'd0, pc_out}, 32'hE000);
    chk("R7 p", {24'd0, p_out}, 32'h05);
    chk("R7 sp", {24'd0, sp}, 32'hFF);
    chk("R7 no writes", wr_cnt - wsave, 0);

    // R8/R10: NMI and IRQ together, NMI first
    @(negedge clk);
    pc_in = 16'h2345; p_in = 8'h10;
    nmi_req = 1'b1; irq_req = 1'b1;
    wait_done();
    chk("R10 nmi first", {28'd0, done_op}, 32'd7);
    chk("R8 pc", {16'd0, pc_out}, 32'h9ABC);
    chk("R8 p", {24'd0, p_out}, 32'h14);
    chk("R8 sp", {24'd0, sp}, 32'hFC);
    @(negedge clk);
    wait_done();
    irq_req = 1'b0;
    chk("R9 irq op", {28'd0, done_op}, 32'd8);
    chk("R9 pc", {16'd0, pc_out}, 32'hC0DE);
    chk("R9 sp", {24'd0, sp}, 32'hF9);
    chk("R8 stack hi", {24'd0, stk[8'hFF]}, 32'h23);
    chk("R8 stack lo", {24'd0, stk[8'hFE]}, 32'h45);
    chk("R8 B clear", {24'd0, stk[8'hFD]}, 32'h00);
    chk("R9 stack hi", {24'd0, stk[8'hFC]}, 32'h23);
    chk("R9 B clear", {24'd0, stk[8'hFA]}, 32'h00);
    quiet(20, "R8 held nmi once");

    // R9: masked IRQ ignored
    @(negedge clk);
    p_in = 8'h04; irq_req = 1'b1;
    quiet(20, "R9 masked");
    chk("R9 ready while masked", {31'd0, cmd_ready}, 32'd1);
    run_cmd(3'd1, 16'h0, 16'h2345, 8'h04, 8'h00, cyc);
    chk("R9 pull under mask", {28'd0, done_op}, 32'd1);
    chk("R2 pull sp", {24'd0, sp}, 32'hFA);
    @(negedge clk);
    irq_req = 1'b0; nmi_req = 1'b0;

    // R10: pending IRQ holds off a command
    @(negedge clk);
    p_in = 8'h00; irq_req = 1'b1;
    @(negedge clk);
    chk("R10 ready low", {31'd0, cmd_ready}, 32'd0);
    cmd_code = 3'd0; push_data = 8'h11; cmd_valid = 1'b1;
    wait_done();
    irq_req = 1'b0;
    chk("R10 irq before cmd", {28'd0, done_op}, 32'd8);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    chk("R10 cmd after", {28'd0, done_op}, 32'd0);
    chk("R10 sp", {24'd0, sp}, 32'hF6);
    chk("R2 pushed byte", {24'd0, stk[8'hF7]}, 32'h11);
    @(negedge clk);
    chk("R11 pulse", {31'd0, done}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule